// File: doc/BRIEF.md
# Redundant-Binary Digit-Pair Partial Product Generator

This block multiplies two short signed numbers held in redundant-binary form. Each operand is a pair of signed digits, and each digit takes the value -1, 0 or +1. It returns the product as a single four-digit redundant-binary partial product, so no carry chain is needed. Each operand pair is first turned into a 3-bit two's complement word by a fixed gate network that needs no carry input. The multiplier word is then decoded into a Booth-style choice: zero, one, two or three times the multiplicand, each with a sign. The datapath wires shifted multiplicand bits onto the positive half of the result, the negative half, or both. It uses neither a multiplier array nor an adder.

The block is purely combinational. It is intended as the leaf element of a larger signed redundant-binary multiplier, in which several of these partial products are summed by carry-free redundant adders placed outside this block.

Each digit is carried on two wires, a positive-weight bit and a negative-weight bit, and its value is plus minus minus. Code `00` is 0, code `10` (plus=1, minus=0) is +1, and code `01` (plus=0, minus=1) is -1. The code `11` is reserved and is never driven into the block. Within a vector, bit index d has weight 2^d.

Top module: `rb_pair_pp`

## Requirements
- R1: For every legal input combination, the sum over d of 2^d·(ppPlus[d] − ppMinus[d]) equals the integer value of the multiplicand pair times the integer value of the multiplier pair. Pair value = 2·digit[1] + digit[0].
- R2: When the multiplier pair has value 0 (for example both digits coded `00`), both ppPlus and ppMinus are all zero.
- R3: No output digit is ever coded `11`: ppPlus & ppMinus is zero for every legal input.
- R4: When the multiplicand is non-negative and the multiplier is +1 or +2, ppMinus is zero. When the multiplicand is non-negative and the multiplier is −1 or −2, ppPlus is zero.
- R5: When the multiplier is +1 or +2, ppMinus equals 4'b1000 if the multiplicand is negative and 4'b0000 otherwise. The multiplicand's sign bit lands on the negative bit of the most significant digit.
- R6: When the multiplicand pair has value 0, both ppPlus and ppMinus are all zero, whatever the multiplier.
- R7: Different legal digit codings of the same operand value produce identical outputs. For example, multiplicand +1 coded as digits (0,+1) and coded as digits (+1,−1) give the same result.
- R8: Hard multiples (multiplier ±3) are formed as a difference of a four-times and a one-times multiplicand, spread over both halves. Any digit position where both halves would be set is cancelled to `00`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcandPlus | input | 2 | Positive-weight bits of the multiplicand digit pair |
| mcandMinus | input | 2 | Negative-weight bits of the multiplicand digit pair |
| mplierPlus | input | 2 | Positive-weight bits of the multiplier digit pair |
| mplierMinus | input | 2 | Negative-weight bits of the multiplier digit pair |
| ppPlus | output | 4 | Positive-weight bits of the partial product digits |
| ppMinus | output | 4 | Negative-weight bits of the partial product digits |

## Verification
The bench uses the package defaults: two digits per operand and a four-digit partial product. With those values the whole legal input space is 3^4 = 81 digit codings, and every one of them is compared against integer multiplication. That sweep covers all seven multiplier values, including both hard multiples. It also reaches every redundant coding of each operand, so the equivalence in R7 and the digit cancellation in R3 and R8 are exercised exhaustively, not only on sampled values.

// File: rtl/rbpp_pkg.sv
package rbpp_pkg;
  localparam int PAIR_DIGITS = 2;
  localparam int TC_W        = PAIR_DIGITS + 1;
  localparam int PP_DIGITS   = 2 * PAIR_DIGITS;
  localparam int N_OPERANDS  = 2;

  // Booth-style selection strobes from control to datapath
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
    logic three;
  } selStrobe_t;
endpackage

// File: rtl/rbpp_tc_conv.sv
module rbpp_tc_conv
  import rbpp_pkg::*;
(
  input  logic [PAIR_DIGITS-1:0] digPlus,
  input  logic [PAIR_DIGITS-1:0] digMinus,
  output logic [TC_W-1:0]        tcWord
);
  // Fixed gate network, zero carry-in, no carry out of the pair
  assign tcWord[0] = digPlus[0] | digMinus[0];
  assign tcWord[1] = digMinus[0] ^ (digPlus[1] | digMinus[1]);
  assign tcWord[2] = ~digPlus[1] & (digMinus[0] | digMinus[1]);
endmodule

// File: rtl/rbpp_booth_ctrl.sv
module rbpp_booth_ctrl
  import rbpp_pkg::*;
(
  input  logic [TC_W-1:0] mplierTc,
  output selStrobe_t      sel
);
  always_comb begin
    sel = '0;
    case (mplierTc)
      3'b001: sel.one = 1'b1;
      3'b010: sel.two = 1'b1;
      3'b011: sel.three = 1'b1;
      3'b111: begin sel.neg = 1'b1; sel.one = 1'b1; end
      3'b110: begin sel.neg = 1'b1; sel.two = 1'b1; end
      3'b101: begin sel.neg = 1'b1; sel.three = 1'b1; end
      default: sel = '0;  // zero multiple; 100 is unreachable from legal digits
    endcase
  end
endmodule

// File: rtl/rbpp_mult_dp.sv
module rbpp_mult_dp
  import rbpp_pkg::*;
(
  input  logic [TC_W-1:0]      mcandTc,
  input  selStrobe_t           sel,
  output logic [PP_DIGITS-1:0] ppPlus,
  output logic [PP_DIGITS-1:0] ppMinus
);
  logic aSign, aMid, aLow;
  logic [PP_DIGITS-1:0] rawPlus, rawMinus;

  assign aSign = mcandTc[2];
  assign aMid  = mcandTc[1];
  assign aLow  = mcandTc[0];

  // Multiples are pure wiring of multiplicand bits onto the two halves
  always_comb begin
    rawPlus  = '0;
    rawMinus = '0;
    if (sel.one && !sel.neg) begin
      rawPlus  = {1'b0, aSign, aMid, aLow};
      rawMinus = {aSign, 3'b000};
    end else if (sel.two && !sel.neg) begin
      rawPlus  = {1'b0, aMid, aLow, 1'b0};
      rawMinus = {aSign, 3'b000};
    end else if (sel.three && !sel.neg) begin
      // +3a = 4a - a
      rawPlus  = {aMid, aLow, 2'b00};
      rawMinus = {aSign, aSign, aMid, aLow};
    end else if (sel.one && sel.neg) begin
      rawPlus  = {1'b0, aSign, 2'b00};
      rawMinus = {2'b00, aMid, aLow};
    end else if (sel.two && sel.neg) begin
      rawPlus  = {aSign, 3'b000};
      rawMinus = {1'b0, aMid, aLow, 1'b0};
    end else if (sel.three && sel.neg) begin
      // -3a = a - 4a
      rawPlus  = {aSign, aSign, aMid, aLow};
      rawMinus = {aMid, aLow, 2'b00};
    end
  end

  // Per-digit cancel keeps every output digit in a legal code
  for (genvar d = 0; d < PP_DIGITS; d++) begin : g_cancel
    assign ppPlus[d]  = rawPlus[d] & ~rawMinus[d];
    assign ppMinus[d] = rawMinus[d] & ~rawPlus[d];
  end
endmodule

// File: rtl/rb_pair_pp.sv
module rb_pair_pp
  import rbpp_pkg::*;
(
  input  logic [PAIR_DIGITS-1:0] mcandPlus,
  input  logic [PAIR_DIGITS-1:0] mcandMinus,
  input  logic [PAIR_DIGITS-1:0] mplierPlus,
  input  logic [PAIR_DIGITS-1:0] mplierMinus,
  output logic [PP_DIGITS-1:0]   ppPlus,
  output logic [PP_DIGITS-1:0]   ppMinus
);
  logic [PAIR_DIGITS-1:0] opPlus  [N_OPERANDS];
  logic [PAIR_DIGITS-1:0] opMinus [N_OPERANDS];
  logic [TC_W-1:0]        opTc    [N_OPERANDS];
  selStrobe_t             sel;

  assign opPlus[0]  = mcandPlus;
  assign opMinus[0] = mcandMinus;
  assign opPlus[1]  = mplierPlus;
  assign opMinus[1] = mplierMinus;

  for (genvar k = 0; k < N_OPERANDS; k++) begin : g_conv
    rbpp_tc_conv u_conv (
      .digPlus  (opPlus[k]),
      .digMinus (opMinus[k]),
      .tcWord   (opTc[k])
    );
  end

  rbpp_booth_ctrl u_ctrl (
    .mplierTc (opTc[1]),
    .sel      (sel)
  );

  rbpp_mult_dp u_dp (
    .mcandTc (opTc[0]),
    .sel     (sel),
    .ppPlus  (ppPlus),
    .ppMinus (ppMinus)
  );
endmodule

// File: rtl/rbpp_checker.sv
module rbpp_checker
  import rbpp_pkg::*;
(
  input logic [PAIR_DIGITS-1:0] mcandPlus,
  input logic [PAIR_DIGITS-1:0] mcandMinus,
  input logic [PAIR_DIGITS-1:0] mplierPlus,
  input logic [PAIR_DIGITS-1:0] mplierMinus,
  input logic [PP_DIGITS-1:0]   ppPlus,
  input logic [PP_DIGITS-1:0]   ppMinus
);
  function automatic int rbValue(input logic [PP_DIGITS-1:0] p, input logic [PP_DIGITS-1:0] m, input int n);
    int acc;
    acc = 0;
    for (int d = 0; d < n; d++) acc += (int'(p[d]) - int'(m[d])) << d;
    return acc;
  endfunction

  logic legalIn;
  int   mcVal, mpVal, ppVal;

  always_comb begin
    legalIn = ~|(mcandPlus & mcandMinus) && ~|(mplierPlus & mplierMinus);
    mcVal = rbValue(PP_DIGITS'(mcandPlus), PP_DIGITS'(mcandMinus), PAIR_DIGITS);
    mpVal = rbValue(PP_DIGITS'(mplierPlus), PP_DIGITS'(mplierMinus), PAIR_DIGITS);
    ppVal = rbValue(ppPlus, ppMinus, PP_DIGITS);
    if (legalIn) begin
      AST_PRODUCT_VALUE: assert (ppVal == mcVal * mpVal) else $error("product mismatch"); // R1
      AST_ZERO_MPLIER: assert (mpVal != 0 || (ppPlus == '0 && ppMinus == '0)) else $error("zero multiplier"); // R2
      AST_LEGAL_DIGITS: assert ((ppPlus & ppMinus) == '0) else $error("reserved digit code"); // R3
      AST_SINGLE_HALF: assert (!(mcVal >= 0 && (mpVal == 1 || mpVal == 2)) || ppMinus == '0) else $error("minus half set"); // R4
      AST_SINGLE_HALF_NEG: assert (!(mcVal >= 0 && (mpVal == -1 || mpVal == -2)) || ppPlus == '0) else $error("plus half set"); // R4
      AST_SIGN_ROUTE: assert (!(mpVal == 1 || mpVal == 2) || ppMinus == ((mcVal < 0) ? 4'b1000 : 4'b0000)) else $error("sign routing"); // R5
      AST_ZERO_MCAND: assert (mcVal != 0 || (ppPlus == '0 && ppMinus == '0)) else $error("zero multiplicand"); // R6
    end
  end
endmodule

bind rb_pair_pp rbpp_checker u_chk (.*);

// File: tb/sim_rb_pair_pp.sv
`timescale 1ns/1ps
module sim_rb_pair_pp;
  localparam int NVEC = 8;
  localparam int WATCHDOG_NS = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mcandPlus, mcandMinus, mplierPlus, mplierMinus;
  logic [3:0] ppPlus, ppMinus;
  int checkCnt = 0;
  int failCnt = 0;

  always #2 clk = ~clk;  // 250 MHz

  rb_pair_pp u0 (
    .mcandPlus (mcandPlus), .mcandMinus (mcandMinus),
    .mplierPlus (mplierPlus), .mplierMinus (mplierMinus),
    .ppPlus (ppPlus), .ppMinus (ppMinus)
  );

  // {mcandPlus, mcandMinus, mplierPlus, mplierMinus}
  localparam logic [7:0] VEC_IN [NVEC] = '{
    8'b00_10_00_11, 8'b00_10_10_00, 8'b11_00_11_00, 8'b00_11_11_00,
    8'b10_01_00_01, 8'b01_10_00_11, 8'b10_00_00_00, 8'b00_00_00_10
  };
  localparam int VEC_EXP [NVEC] = '{6, -4, 9, -9, -1, 3, 0, 0};

  function automatic int digVal(input logic p, input logic m);
    return int'(p) - int'(m);
  endfunction

  function automatic int pairVal(input logic [1:0] p, input logic [1:0] m);
    return 2 * digVal(p[1], m[1]) + digVal(p[0], m[0]);
  endfunction

  function automatic int ppVal(input logic [3:0] p, input logic [3:0] m);
    int acc;
    acc = 0;
    for (int d = 0; d < 4; d++) acc += digVal(p[d], m[d]) * (1 << d);
    return acc;
  endfunction

  // legal digit code k: 0 -> 00 (0), 1 -> 10 (+1), 2 -> 01 (-1)
  function automatic logic [1:0] digCode(input int k);
    return (k == 1) ? 2'b10 : (k == 2) ? 2'b01 : 2'b00;
  endfunction

  task automatic checkInt(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] v);
    @(negedge clk);
    {mcandPlus, mcandMinus, mplierPlus, mplierMinus} = v;
    #1;
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    #(WATCHDOG_NS);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    logic [3:0] refPlus, refMinus;
    {mcandPlus, mcandMinus, mplierPlus, mplierMinus} = '0;
    repeat (3) @(posedge clk);
    #1;
    // reset state: all-zero inputs give an all-zero result (R2, R6)
    checkInt("R2 reset plus", int'(ppPlus), 0);
    checkInt("R6 reset minus", int'(ppMinus), 0);
    rstN = 1'b1;

    // directed table, including hard multiples (R8)
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC_IN[i]);
      checkInt("R1/R8 table value", ppVal(ppPlus, ppMinus), VEC_EXP[i]);
      checkInt("R3 table legal", int'(ppPlus & ppMinus), 0);
    end

    // exhaustive sweep over every legal coding
    for (int idx = 0; idx < 81; idx++) begin
      int c0, c1, c2, c3, a, m;
      c0 = idx % 3; c1 = (idx / 3) % 3; c2 = (idx / 9) % 3; c3 = (idx / 27) % 3;
      apply({digCode(c1)[1], digCode(c0)[1], digCode(c1)[0], digCode(c0)[0],
             digCode(c3)[1], digCode(c2)[1], digCode(c3)[0], digCode(c2)[0]});
      a = pairVal(mcandPlus, mcandMinus);
      m = pairVal(mplierPlus, mplierMinus);
      checkInt("R1 sweep value", ppVal(ppPlus, ppMinus), a * m);
      checkInt("R3 sweep legal", int'(ppPlus & ppMinus), 0);
      if (m == 0) checkInt("R2 zero multiplier", int'({ppPlus, ppMinus}), 0);
      if (a == 0) checkInt("R6 zero multiplicand", int'({ppPlus, ppMinus}), 0);
      if (a >= 0 && (m == 1 || m == 2)) checkInt("R4 minus half", int'(ppMinus), 0);
      if (a >= 0 && (m == -1 || m == -2)) checkInt("R4 plus half", int'(ppPlus), 0);
      if (m == 1 || m == 2) checkInt("R5 sign route", int'(ppMinus), (a < 0) ? 8 : 0);
      if (m == 3 || m == -3) checkInt("R8 hard multiple", ppVal(ppPlus, ppMinus), a * m);
    end

    // R7: multiplicand +1 as (0,+1) versus (+1,-1), for each multiplier coding
    for (int k = 0; k < 9; k++) begin
      logic [1:0] mp, mm;
      mp = {digCode(k / 3)[1], digCode(k % 3)[1]};
      mm = {digCode(k / 3)[0], digCode(k % 3)[0]};
      apply({2'b01, 2'b00, mp, mm});
      refPlus = ppPlus;
      refMinus = ppMinus;
      apply({2'b10, 2'b01, mp, mm});
      checkInt("R7 coding plus", int'(ppPlus), int'(refPlus));
      checkInt("R7 coding minus", int'(ppMinus), int'(refMinus));
    end

    finishRun();
  end
endmodule